// File: doc/BRIEF.md
# Programmable Spike Address Decoder

This block sits at the receiving end of a shared event bus on which each transfer carries only the identity of a source node that has fired. A four-phase request/acknowledge handshake delivers the source address, and the block treats every completed transfer as exactly one spike from that source. It looks the address up in a routing table and produces a single-cycle pulse on the target line named by the table entry. The event's timing is carried only by the cycle in which that pulse appears.

The routing table is held in storage that a host loads at run time, so the wiring from sources to targets can be changed after fabrication. Each entry holds a target index and an enable bit; a source whose entry is disabled is acknowledged but drives no output. Host writes are refused while a handshake is under way, so a lookup always reads a complete entry. The request input comes from outside the clock domain and is synchronised before it is used. The address must be stable whenever the request is high.

Top module: `spike_route_decoder`

## Requirements
- R1: After reset `spike_out` is zero, `ev_ack` is low, and every table entry is disabled, so that any event produces no pulse.
- R2: For an enabled entry, one event produces exactly one pulse. The pulse lasts one clock cycle and sets bit `t` of `spike_out`, where `t` is the entry's target field. It appears on the (SYNC_STAGES+2)-th rising edge after `ev_req` rises.
- R3: For a disabled entry, an event produces no pulse, and the handshake still completes.
- R4: `ev_ack` rises on the (SYNC_STAGES+3)-th rising edge after `ev_req` rises, which is the cycle after the pulse slot. It stays high while `ev_req` is high and falls on the (SYNC_STAGES+1)-th edge after `ev_req` falls.
- R5: A host write with `host_we` high writes `host_tgt` and `host_en` into the entry at `host_addr` on one clock edge while the block is idle. Later events on that source use the new entry.
- R6: A host write presented while a handshake is in progress (synchronised request high, lookup pending, or `ev_ack` high) is discarded, and the entry keeps its old contents.
- R7: Events are reported in arrival order: each handshake's pulse, if any, appears before the next handshake begins.
- R8: At most one bit of `spike_out` is high in any cycle, and no bit is high while `ev_ack` is high.
- R9: The address is captured once per handshake. Changing `ev_addr` or holding `ev_req` high after capture produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 1 | Bus request, asynchronous, four-phase |
| ev_addr | input | $clog2(NUM_SRC) | Source address, stable while request is high |
| ev_ack | output | 1 | Bus acknowledge |
| host_we | input | 1 | Table write enable |
| host_addr | input | $clog2(NUM_SRC) | Table entry to write |
| host_tgt | input | $clog2(NUM_TGT) | Target index to store |
| host_en | input | 1 | Enable bit to store |
| spike_out | output | NUM_TGT | One-cycle pulse per routed event |

## Verification
A host table write and a bus handshake can land in the same cycle. In that cycle the write has to be refused rather than let it race the lookup. The bench provokes this by issuing a write to another source's entry while `ev_ack` is high. It then sends an event to that source and judges the outcome by the target line that pulses: the old mapping must still be in force. A second case writes an entry in the idle cycle just before a request arrives, and the event that follows must already use the new target.

// File: rtl/spike_route_pkg.sv
package spike_route_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_PULSE = 2'd2,
    ST_ACK   = 2'd3
  } route_state_t;
endpackage

// File: rtl/spike_route_sync.sv
module spike_route_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/spike_route_table.sv
module spike_route_table #(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 8,
  localparam int SRC_W = $clog2(NUM_SRC),
  localparam int TGT_W = $clog2(NUM_TGT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_addr,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic             wr_valid,
  input  logic             rd_en,
  input  logic [SRC_W-1:0] rd_addr,
  output logic [TGT_W-1:0] rd_tgt,
  output logic             rd_valid
);
  // Target fields live in a plain array with a registered read (RAM style);
  // enable bits are flops so that reset clears them.
  logic [TGT_W-1:0]   tgt_mem [NUM_SRC];
  logic [NUM_SRC-1:0] en_bits;

  always_ff @(posedge clk) begin
    if (wr_en) tgt_mem[wr_addr] <= wr_tgt;
    if (rd_en) rd_tgt <= tgt_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_bits  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) en_bits[wr_addr] <= wr_valid;
      if (rd_en) rd_valid <= en_bits[rd_addr];
    end
  end
endmodule

// File: rtl/spike_route_ctrl.sv
module spike_route_ctrl
  import spike_route_pkg::*;
#(
  parameter int NUM_TGT = 8,
  localparam int TGT_W = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_s,
  input  logic [TGT_W-1:0]   rd_tgt,
  input  logic               rd_valid,
  output logic               lookup,
  output logic               busy,
  output logic               ack,
  output logic [NUM_TGT-1:0] spike
);
  route_state_t state;
  logic [NUM_TGT-1:0] decoded;

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_dec
      assign decoded[t] = rd_valid && (rd_tgt == TGT_W'(t));
    end
  endgenerate

  assign lookup = (state == ST_IDLE) && req_s;
  assign busy   = (state != ST_IDLE) || req_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ack   <= 1'b0;
      spike <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_s) state <= ST_READ;
        end
        ST_READ: begin
          spike <= decoded;
          state <= ST_PULSE;
        end
        ST_PULSE: begin
          spike <= '0;
          ack   <= 1'b1;
          state <= ST_ACK;
        end
        default: begin
          if (!req_s) begin
            ack   <= 1'b0;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spike_route_decoder.sv
module spike_route_decoder #(
  parameter int NUM_SRC     = 8,
  parameter int NUM_TGT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ev_req,
  input  logic [$clog2(NUM_SRC)-1:0] ev_addr,
  output logic                       ev_ack,
  input  logic                       host_we,
  input  logic [$clog2(NUM_SRC)-1:0] host_addr,
  input  logic [$clog2(NUM_TGT)-1:0] host_tgt,
  input  logic                       host_en,
  output logic [NUM_TGT-1:0]         spike_out
);
  localparam int TGT_W = $clog2(NUM_TGT);

  logic             req_s;
  logic             lookup;
  logic             busy;
  logic             tbl_we;
  logic [TGT_W-1:0] rd_tgt;
  logic             rd_valid;

  assign tbl_we = host_we && !busy;

  spike_route_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(ev_req), .d_out(req_s)
  );

  spike_route_table #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we), .wr_addr(host_addr), .wr_tgt(host_tgt), .wr_valid(host_en),
    .rd_en(lookup), .rd_addr(ev_addr), .rd_tgt(rd_tgt), .rd_valid(rd_valid)
  );

  spike_route_ctrl #(.NUM_TGT(NUM_TGT)) u_ctrl (
    .clk(clk), .rst(rst), .req_s(req_s), .rd_tgt(rd_tgt), .rd_valid(rd_valid),
    .lookup(lookup), .busy(busy), .ack(ev_ack), .spike(spike_out)
  );
endmodule

// File: rtl/spike_route_decoder_chk.sv
module spike_route_decoder_chk #(
  parameter int NUM_TGT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ev_req,
  input logic               ev_ack,
  input logic               tbl_we,
  input logic [NUM_TGT-1:0] spike_out
);
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(spike_out));

  assert_quiet_under_ack_R8: assert property (@(posedge clk) disable iff (rst)
    ev_ack |-> (spike_out == '0));

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    (spike_out != '0) |=> (spike_out == '0));

  assert_ack_after_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (spike_out != '0) |=> ev_ack);

  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_ack && ev_req) |=> ev_ack);

  assert_write_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> !ev_ack);
endmodule

bind spike_route_decoder spike_route_decoder_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk(clk), .rst(rst), .ev_req(ev_req), .ev_ack(ev_ack),
  .tbl_we(tbl_we), .spike_out(spike_out)
);

// File: tb/spike_route_decoder_test.sv
module spike_route_decoder_test;
  localparam int NS = 8;
  localparam int NT = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_req = 1'b0;
  logic [2:0] ev_addr = '0;
  logic ev_ack;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [2:0] host_tgt = '0;
  logic host_en = 1'b0;
  logic [NT-1:0] spike_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spike_route_decoder #(.NUM_SRC(NS), .NUM_TGT(NT), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .ev_req(ev_req), .ev_addr(ev_addr), .ev_ack(ev_ack),
    .host_we(host_we), .host_addr(host_addr), .host_tgt(host_tgt),
    .host_en(host_en), .spike_out(spike_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int t, input bit en);
    @(negedge clk);
    host_we = 1'b1; host_addr = 3'(a); host_tgt = 3'(t); host_en = en;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic send_event(input int src, input bit exp_v, input int exp_t,
                            input bit meddle, input int m_addr, input int m_tgt);
    int pulses = 0;
    int pulse_at = -1;
    int ack_at = -1;
    int rel_at = -1;
    int late = 0;
    int multi = 0;
    logic [NT-1:0] seen = '0;
    @(negedge clk);
    ev_addr = 3'(src); ev_req = 1'b1;
    for (int i = 1; i <= 20 && ack_at < 0; i++) begin
      @(negedge clk);
      if ($countones(spike_out) > 1) multi++;
      if (spike_out != '0) begin pulses++; pulse_at = i; seen = spike_out; end
      if (ev_ack) begin
        ack_at = i;
        if (spike_out != '0) multi++;
      end
    end
    check(multi == 0, "R8", multi, 0);
    if (exp_v) begin
      check(pulses == 1, "R2", pulses, 1);
      check(seen == NT'(1) << exp_t, "R2", int'(seen), 1 << exp_t);
      check(pulse_at == SYNC + 2, "R2", pulse_at, SYNC + 2);
    end else begin
      check(pulses == 0, "R3", pulses, 0);
    end
    check(ack_at == SYNC + 3, "R4", ack_at, SYNC + 3);
    if (meddle) begin
      host_we = 1'b1; host_addr = 3'(m_addr); host_tgt = 3'(m_tgt); host_en = 1'b1;
      ev_addr = ~3'(src);
      @(negedge clk);
      host_we = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (spike_out != '0) late++;
        check(ev_ack == 1'b1, "R4", int'(ev_ack), 1);
      end
      check(late == 0, "R9", late, 0);
    end
    ev_req = 1'b0;
    late = 0;
    for (int i = 1; i <= 20 && rel_at < 0; i++) begin
      @(negedge clk);
      if (spike_out != '0) late++;
      if (!ev_ack) rel_at = i;
    end
    check(rel_at == SYNC + 1, "R4", rel_at, SYNC + 1);
    check(late == 0, "R9", late, 0);
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(spike_out == '0, "R1", int'(spike_out), 0);
    check(ev_ack == 1'b0, "R1", int'(ev_ack), 0);
    // R1 / R3: every entry starts disabled
    for (int s = 0; s < NS; s++) send_event(s, 1'b0, 0, 1'b0, 0, 0);

    // R5 / R2 / R3: even sources enabled, target (3s+1) mod 8
    for (int s = 0; s < NS; s++) host_write(s, (s * 3 + 1) % NT, (s % 2) == 0);
    for (int s = 0; s < NS; s++) send_event(s, (s % 2) == 0, (s * 3 + 1) % NT, 1'b0, 0, 0);

    // R5: remap every source to target 7-s, all enabled
    for (int s = 0; s < NS; s++) host_write(s, NT - 1 - s, 1'b1);
    for (int s = NS - 1; s >= 0; s--) send_event(s, 1'b1, NT - 1 - s, 1'b0, 0, 0);

    // R6 / R9: write during acknowledge is discarded, address change ignored
    send_event(2, 1'b1, 5, 1'b1, 5, 0);
    send_event(5, 1'b1, 2, 1'b0, 0, 0);

    // R5: write in the idle cycle just before a request takes effect
    host_write(1, 4, 1'b1);
    send_event(1, 1'b1, 4, 1'b0, 0, 0);

    // R3: disabling an entry silences it
    host_write(6, 3, 1'b0);
    send_event(6, 1'b0, 0, 1'b0, 0, 0);

    // R7: back-to-back events report in arrival order
    send_event(3, 1'b1, 4, 1'b0, 0, 0);
    send_event(0, 1'b1, 7, 1'b0, 0, 0);
    send_event(7, 1'b1, 0, 1'b0, 0, 0);
    send_event(1, 1'b1, 4, 1'b0, 0, 0);

    done = 1'b1;
    report();
  end
endmodule